// File: doc/BRIEF.md
# Gated Multi-Chain Scan Test Controller

This controller sequences scan test for a circuit whose scan cells are split into several regular chains plus one extra chain. The extra chain holds the cells whose switching cannot be masked from the primary inputs. Each chain gets its own clock enable. In test mode only one enable is ever active, so only one chain's clock tree toggles during shifting. The single scan-in line fans out to every chain. The scan-out pin follows whichever chain is currently enabled.

While a regular chain shifts, the controller drives the circuit's primary inputs with a constant masking vector that belongs to that chain. Software loads these vectors into a small register file, one entry per chain. The vector does not depend on the data being shifted. It only keeps the combinational logic quiet.

A pattern starts with a one-cycle `start` pulse. The regular chains shift in index order, each for its programmed length. The extra chain then shifts for its own length while the pattern's primary-input bits are applied. One capture cycle follows, and then a one-cycle `done` pulse. Setting `func_mode` high forces every enable on, hands the primary inputs back to the functional source and parks the sequencer.

Top module: `gated_scan_ctl`

## Requirements
- R1: `chain_si` carries `scan_in` on every bit (all NCH+1 chains) at all times.
- R2: After synchronous reset with `func_mode` low, `chain_en` is all zero, `capture` and `done` are 0, and `pi_out` equals `func_pi`.
- R3: While `func_mode` is 1, `chain_en` is all ones, `pi_out` equals `func_pi`, and a `start` pulse launches nothing: after `func_mode` returns to 0, `chain_en` stays zero and no `done` appears.
- R4: With `func_mode` low, at most one bit of `chain_en` is set.
- R5: One cycle after `start` is sampled while idle, `chain_en` bit 0 goes high. Chain j (bit j, for j below NCH) is then enabled for exactly `chain_len[j]` consecutive cycles, in increasing j with no gap. Field j of `chain_len` is bits [j*LENW +: LENW], and every regular length must be at least 1.
- R6: While regular chain j is enabled, `pi_out` equals entry j of the masking-vector file.
- R7: After the last regular chain, bit NCH of `chain_en` (the extra chain) is high for `xlen` cycles. During that time `pi_out` equals the `pat_pi` value sampled on the start cycle; later changes of `pat_pi` have no effect.
- R8: When `xlen` is 0 the extra-chain phase is skipped, and capture follows the last regular chain at once.
- R9: `capture` is high for exactly one cycle, immediately after the last shift cycle. In that cycle `chain_en` is zero and `pi_out` is the sampled pattern value. `done` is high for one cycle right after capture, with `pi_out` back at `func_pi`.
- R10: `scan_out` equals the `chain_so` bit of the enabled chain, and is 0 when no chain is enabled in test mode.
- R11: A `start` pulse during a pattern in progress is ignored, and the sequence continues unchanged.
- R12: A cycle with `qv_we` high writes `qv_wdata` into entry `qv_addr`, and patterns launched afterwards use the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| func_mode | input | 1 | 1 = functional operation, 0 = test |
| start | input | 1 | Launch one pattern when idle |
| scan_in | input | 1 | Serial test data in |
| chain_len | input | NCH*LENW | Lengths of the regular chains, field j for chain j |
| xlen | input | LENW | Extra-chain length (0 allowed) |
| qv_we | input | 1 | Masking-vector write strobe |
| qv_addr | input | AW | Masking-vector entry index |
| qv_wdata | input | PIW | Masking-vector write data |
| pat_pi | input | PIW | Primary-input part of the current pattern |
| func_pi | input | PIW | Functional primary-input source |
| chain_so | input | NCH+1 | Serial outputs of the chains, bit NCH = extra chain |
| chain_si | output | NCH+1 | Serial inputs of the chains |
| chain_en | output | NCH+1 | Per-chain clock enables |
| capture | output | 1 | Response capture strobe |
| done | output | 1 | Pattern finished pulse |
| pi_out | output | PIW | Primary inputs to the circuit under test |
| scan_out | output | 1 | Serial test data out |

## Verification
The assertions assume that every regular chain length is nonzero and that lengths stay stable while a pattern runs. They also assume that `func_mode` does not rise in the middle of a capture cycle. The stimulus draws regular lengths from 1 to 12 and extra lengths from 0 to 6, and changes lengths and vectors only between patterns. It toggles `func_mode` only while the sequencer is idle. Random `start` pulses are injected only inside shift phases, where the sequencer must ignore them.

// File: rtl/scan_ctl_pkg.sv
package scan_ctl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SHIFT  = 2'd1,
    PH_XSHIFT = 2'd2,
    PH_CAPT   = 2'd3
  } phase_t;
endpackage

// File: rtl/scan_qv_file.sv
module scan_qv_file #(
  parameter int NCH = 4,
  parameter int PIW = 8,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [PIW-1:0] wdata,
  input  logic [AW-1:0]  raddr,
  output logic [PIW-1:0] rdata
);
  // distributed-RAM style storage, one masking vector per regular chain
  logic [PIW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < NCH)) mem[waddr] <= wdata;
  end

  assign rdata = (int'(raddr) < NCH) ? mem[raddr] : '0;
endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_ctl_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int LENW = 6,
  parameter int PIW  = 8,
  localparam int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              func_mode,
  input  logic              start,
  input  logic [NCH*LENW-1:0] chain_len,
  input  logic [LENW-1:0]   xlen,
  input  logic [PIW-1:0]    pat_pi,
  input  logic [PIW-1:0]    qv_rdata,
  output logic [AW-1:0]     qv_raddr,
  output logic [NCH:0]      en_q,
  output logic [PIW-1:0]    pi_q,
  output logic              pi_test,
  output logic              capture,
  output logic              done
);
  phase_t          phase;
  logic [AW-1:0]   idx;
  logic [LENW-1:0] cnt;
  logic [PIW-1:0]  pat_q;
  logic [LENW-1:0] cur_len;
  logic            seg_last;
  logic            x_last;
  logic            idx_last;

  assign cur_len  = chain_len[idx*LENW +: LENW];
  assign seg_last = (cnt == cur_len - LENW'(1));
  assign x_last   = (cnt == xlen - LENW'(1));
  assign idx_last = (idx == AW'(NCH - 1));
  // look-ahead read: vector of the chain about to be entered
  assign qv_raddr = (phase == PH_IDLE) ? '0 : AW'(idx + AW'(1));

  always_ff @(posedge clk) begin
    if (rst || func_mode) begin
      phase   <= PH_IDLE;
      idx     <= '0;
      cnt     <= '0;
      en_q    <= '0;
      pi_q    <= '0;
      pat_q   <= '0;
      pi_test <= 1'b0;
      capture <= 1'b0;
      done    <= 1'b0;
    end else begin
      capture <= 1'b0;
      done    <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_SHIFT;
            idx     <= '0;
            cnt     <= '0;
            en_q    <= (NCH+1)'(1);
            pi_q    <= qv_rdata;
            pat_q   <= pat_pi;
            pi_test <= 1'b1;
          end
        end
        PH_SHIFT: begin
          if (seg_last) begin
            cnt <= '0;
            if (idx_last) begin
              pi_q <= pat_q;
              if (xlen != '0) begin
                phase <= PH_XSHIFT;
                en_q  <= {1'b1, {NCH{1'b0}}};
              end else begin
                phase   <= PH_CAPT;
                en_q    <= '0;
                capture <= 1'b1;
              end
            end else begin
              idx  <= AW'(idx + AW'(1));
              en_q <= en_q << 1;
              pi_q <= qv_rdata;
            end
          end else begin
            cnt <= cnt + LENW'(1);
          end
        end
        PH_XSHIFT: begin
          if (x_last) begin
            phase   <= PH_CAPT;
            cnt     <= '0;
            en_q    <= '0;
            capture <= 1'b1;
          end else begin
            cnt <= cnt + LENW'(1);
          end
        end
        PH_CAPT: begin
          phase   <= PH_IDLE;
          pi_test <= 1'b0;
          done    <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_out_sel.sv
module scan_out_sel #(
  parameter int NCH = 4
) (
  input  logic         func_mode,
  input  logic [NCH:0] en_q,
  input  logic [NCH:0] chain_so,
  output logic [NCH:0] chain_en,
  output logic         scan_out
);
  logic [NCH:0] gated;

  for (genvar g = 0; g <= NCH; g++) begin : g_lane
    assign chain_en[g] = en_q[g] | func_mode;
    assign gated[g]    = en_q[g] & chain_so[g];
  end

  assign scan_out = !func_mode && (|gated);
endmodule

// File: rtl/gated_scan_ctl.sv
module gated_scan_ctl #(
  parameter int NCH  = 4,
  parameter int LENW = 6,
  parameter int PIW  = 8,
  localparam int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                func_mode,
  input  logic                start,
  input  logic                scan_in,
  input  logic [NCH*LENW-1:0] chain_len,
  input  logic [LENW-1:0]     xlen,
  input  logic                qv_we,
  input  logic [AW-1:0]       qv_addr,
  input  logic [PIW-1:0]      qv_wdata,
  input  logic [PIW-1:0]      pat_pi,
  input  logic [PIW-1:0]      func_pi,
  input  logic [NCH:0]        chain_so,
  output logic [NCH:0]        chain_si,
  output logic [NCH:0]        chain_en,
  output logic                capture,
  output logic                done,
  output logic [PIW-1:0]      pi_out,
  output logic                scan_out
);
  logic [AW-1:0]  qv_raddr;
  logic [PIW-1:0] qv_rdata;
  logic [NCH:0]   en_q;
  logic [PIW-1:0] pi_q;
  logic           pi_test;

  scan_qv_file #(.NCH(NCH), .PIW(PIW)) u_qv (
    .clk   (clk),
    .we    (qv_we),
    .waddr (qv_addr),
    .wdata (qv_wdata),
    .raddr (qv_raddr),
    .rdata (qv_rdata)
  );

  scan_seq_fsm #(.NCH(NCH), .LENW(LENW), .PIW(PIW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .func_mode (func_mode),
    .start     (start),
    .chain_len (chain_len),
    .xlen      (xlen),
    .pat_pi    (pat_pi),
    .qv_rdata  (qv_rdata),
    .qv_raddr  (qv_raddr),
    .en_q      (en_q),
    .pi_q      (pi_q),
    .pi_test   (pi_test),
    .capture   (capture),
    .done      (done)
  );

  scan_out_sel #(.NCH(NCH)) u_sel (
    .func_mode (func_mode),
    .en_q      (en_q),
    .chain_so  (chain_so),
    .chain_en  (chain_en),
    .scan_out  (scan_out)
  );

  assign chain_si = {(NCH+1){scan_in}};
  assign pi_out   = (pi_test && !func_mode) ? pi_q : func_pi;
endmodule

// File: rtl/gated_scan_ctl_chk.sv
module gated_scan_ctl_chk #(
  parameter int NCH = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         func_mode,
  input logic [NCH:0] chain_en,
  input logic         capture,
  input logic         done,
  input logic         scan_out
);
  // R4
  onehot_en_chk: assert property (@(posedge clk) disable iff (rst)
    !func_mode |-> $onehot0(chain_en));

  // R3
  func_all_on_chk: assert property (@(posedge clk) disable iff (rst)
    func_mode |-> (&chain_en));

  // R9
  capt_single_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> !capture);

  // R9
  done_after_capt_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(capture));

  // R9
  capt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (capture && !func_mode) |-> (chain_en == '0));

  // R2
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !func_mode) |-> (chain_en == '0 && !capture && !done));

  // R10
  idle_so_chk: assert property (@(posedge clk) disable iff (rst)
    (!func_mode && chain_en == '0) |-> !scan_out);
endmodule

bind gated_scan_ctl gated_scan_ctl_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .func_mode (func_mode),
  .chain_en  (chain_en),
  .capture   (capture),
  .done      (done),
  .scan_out  (scan_out)
);

// File: tb/gated_scan_ctl_tb.sv
module gated_scan_ctl_tb;
  localparam int NCH  = 4;
  localparam int LENW = 6;
  localparam int PIW  = 8;
  localparam int AW   = 2;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                func_mode = 1'b0;
  logic                start = 1'b0;
  logic                scan_in = 1'b0;
  logic [NCH*LENW-1:0] chain_len = '0;
  logic [LENW-1:0]     xlen = '0;
  logic                qv_we = 1'b0;
  logic [AW-1:0]       qv_addr = '0;
  logic [PIW-1:0]      qv_wdata = '0;
  logic [PIW-1:0]      pat_pi = '0;
  logic [PIW-1:0]      func_pi = '0;
  logic [NCH:0]        chain_so = '0;
  logic [NCH:0]        chain_si;
  logic [NCH:0]        chain_en;
  logic                capture;
  logic                done;
  logic [PIW-1:0]      pi_out;
  logic                scan_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int lens [NCH];
  int xl;
  logic [PIW-1:0] qv_model [NCH];

  gated_scan_ctl #(.NCH(NCH), .LENW(LENW), .PIW(PIW)) u_dut (
    .clk(clk), .rst(rst), .func_mode(func_mode), .start(start),
    .scan_in(scan_in), .chain_len(chain_len), .xlen(xlen),
    .qv_we(qv_we), .qv_addr(qv_addr), .qv_wdata(qv_wdata),
    .pat_pi(pat_pi), .func_pi(func_pi), .chain_so(chain_so),
    .chain_si(chain_si), .chain_en(chain_en), .capture(capture),
    .done(done), .pi_out(pi_out), .scan_out(scan_out)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NCH:0] onehot(input int j);
    logic [NCH:0] v = '0;
    v[j] = 1'b1;
    return v;
  endfunction

  task automatic set_lens();
    for (int j = 0; j < NCH; j++) chain_len[j*LENW +: LENW] = LENW'(lens[j]);
    xlen = LENW'(xl);
  endtask

  task automatic write_qv(input int a, input logic [PIW-1:0] v);
    @(negedge clk);
    qv_we = 1'b1; qv_addr = AW'(a); qv_wdata = v;
    @(negedge clk);
    qv_we = 1'b0;
    qv_model[a] = v;
  endtask

  // launch one pattern and check every cycle until the done pulse
  task automatic run_pattern(input int inject_at);
    int sreg = 0;
    int total;
    logic [PIW-1:0] pat;
    for (int j = 0; j < NCH; j++) sreg += lens[j];
    total = sreg + xl;
    pat = PIW'($urandom);
    @(negedge clk);
    pat_pi = pat; start = 1'b1;
    @(negedge clk);
    start = 1'b0; pat_pi = ~pat;
    for (int c = 0; c <= total + 1; c++) begin
      logic [NCH:0] e_en;
      logic [PIW-1:0] e_pi;
      logic e_cap, e_done, e_so;
      string t_en, t_pi, t_cap;
      func_pi  = PIW'($urandom);
      chain_so = (NCH+1)'($urandom);
      #1;
      e_cap = 1'b0; e_done = 1'b0; e_so = 1'b0;
      t_cap = "R9";
      if (c < sreg) begin
        int acc = 0;
        int jj = 0;
        for (int j = 0; j < NCH; j++) begin
          if (c >= acc && c < acc + lens[j]) jj = j;
          acc += lens[j];
        end
        e_en = onehot(jj); e_pi = qv_model[jj]; e_so = chain_so[jj];
        t_en = "R5"; t_pi = "R6";
      end else if (c < total) begin
        e_en = onehot(NCH); e_pi = pat; e_so = chain_so[NCH];
        t_en = "R7"; t_pi = "R7";
      end else if (c == total) begin
        e_en = '0; e_pi = pat; e_cap = 1'b1;
        t_en = (xl == 0) ? "R8" : "R9"; t_pi = "R9";
        if (xl == 0) t_cap = "R8";
      end else begin
        e_en = '0; e_pi = func_pi; e_done = 1'b1;
        t_en = "R9"; t_pi = "R9";
      end
      if (inject_at >= 0 && c > inject_at) begin
        t_en = {t_en, "/R11"};
      end
      chk(chain_en == e_en, t_en, 64'(chain_en), 64'(e_en));
      chk(pi_out == e_pi, t_pi, 64'(pi_out), 64'(e_pi));
      chk(capture == e_cap, t_cap, 64'(capture), 64'(e_cap));
      chk(done == e_done, "R9 done", 64'(done), 64'(e_done));
      chk(scan_out == e_so, "R10", 64'(scan_out), 64'(e_so));
      start = (c == inject_at) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5CA1_7E57));
    for (int j = 0; j < NCH; j++) begin lens[j] = 1; qv_model[j] = '0; end
    xl = 0;
    set_lens();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    func_pi = 8'h3C;
    #1;
    // R2 reset state
    chk(chain_en == '0, "R2 en", 64'(chain_en), 64'(0));
    chk(!capture && !done, "R2 cap/done", 64'({capture, done}), 64'(0));
    chk(pi_out == func_pi, "R2 pi", 64'(pi_out), 64'(func_pi));

    // R1 broadcast
    scan_in = 1'b1; #1;
    chk(chain_si == '1, "R1", 64'(chain_si), 64'({(NCH+1){1'b1}}));
    scan_in = 1'b0; #1;
    chk(chain_si == '0, "R1", 64'(chain_si), 64'(0));

    // R12 load masking vectors
    for (int j = 0; j < NCH; j++) write_qv(j, PIW'($urandom));

    // directed: all lengths 1, no extra chain (R8)
    run_pattern(-1);
    // directed: extra chain of 1
    xl = 1; set_lens();
    run_pattern(-1);

    // R3 functional mode forces enables and ignores start
    @(negedge clk);
    func_mode = 1'b1; func_pi = 8'hA5; #1;
    chk(chain_en == '1, "R3 en", 64'(chain_en), 64'({(NCH+1){1'b1}}));
    chk(pi_out == 8'hA5, "R3 pi", 64'(pi_out), 64'(8'hA5));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    func_mode = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(chain_en == '0, "R3 no launch", 64'(chain_en), 64'(0));
      chk(!done, "R3 no done", 64'(done), 64'(0));
      @(negedge clk);
    end

    // random patterns, some with injected start pulses (R11)
    for (int p = 0; p < 40; p++) begin
      int inj;
      int sreg = 0;
      for (int j = 0; j < NCH; j++) begin
        lens[j] = 1 + int'($urandom_range(11));
        sreg += lens[j];
      end
      xl = (p % 5 == 0) ? 0 : int'($urandom_range(6));
      set_lens();
      if (p % 7 == 3) write_qv(p % NCH, PIW'($urandom)); // R12 rewrite
      inj = (p % 3 == 1) ? int'($urandom_range(sreg - 1)) : -1;
      run_pattern(inj);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule